// File: doc/BRIEF.md
# Add/Subtract Unit with Status Flags

This block performs an 8-bit add or subtract on two operands and derives the condition flags a small accumulator machine keeps in its status byte: carry/borrow, half-carry across the nibble boundary, signed overflow and result parity. Zero and negative flags come out on separate pins for observation. Four operations are selected by a two-bit code: plain add, add with carry, plain subtract and subtract with borrow. The carry-in pin only matters in the two "with carry" forms.

The unit also assembles the full status byte. Three bits of it are the user flag and the two register-bank select bits. These come from a held register outside the block and pass through unchanged. The flags fill the remaining positions. All outputs are registered, so results appear one clock after the inputs are presented. A synchronous active-high reset clears every output.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs become zero on that edge and stay zero until a later edge with `rst` low.
- R2: One clock after the inputs are sampled, `res_q` holds the low 8 bits of the operation chosen by `op_sel`: 00 gives A+B, 01 gives A+B+carry_in, 10 gives A−B and 11 gives A−B−carry_in. Bits past bit 7 are dropped, and `carry_in` has no effect for codes 00 and 10.
- R3: For add codes, `cy_q` is the carry out of bit 7. For example, 01h+FFh gives 00h with `cy_q`=1.
- R4: For subtract codes, `cy_q` is 1 exactly when A is less than B plus the borrow-in, taken as unsigned numbers.
- R5: `ac_q` is the carry out of bit 3 for add codes. For subtract codes it is 1 when the low nibble of A is less than the low nibble of B plus the borrow-in.
- R6: For add codes, `ov_q` is 1 only when both operands have the same sign bit and the result's sign bit differs from it. Operands of mixed sign never set it.
- R7: For subtract codes, `ov_q` is 1 only when A and B differ in sign and the result's sign differs from A's.
- R8: `par_q` is 1 when `res_q` holds an odd number of ones.
- R9: `zero_q` is 1 exactly when `res_q` is 00h, and `neg_q` equals bit 7 of `res_q`.
- R10: `stat_q` packs the flags as follows: bit 7 `cy_q`, bit 6 `ac_q`, bit 5 `hold_bits[2]` (user flag), bit 4 `hold_bits[1]` and bit 3 `hold_bits[0]` (bank select), bit 2 `ov_q`, bit 1 `zero_q`, bit 0 `par_q`. The hold bits are taken from the same cycle as the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opd_a | input | 8 | First operand (minuend for subtract) |
| opd_b | input | 8 | Second operand (subtrahend for subtract) |
| carry_in | input | 1 | Carry or borrow input for codes 01 and 11 |
| op_sel | input | 2 | Operation code |
| hold_bits | input | 3 | User flag and bank select bits to pass through |
| res_q | output | 8 | Registered result |
| cy_q | output | 1 | Carry / borrow flag |
| ac_q | output | 1 | Nibble carry / borrow flag |
| ov_q | output | 1 | Signed overflow flag |
| par_q | output | 1 | Parity flag |
| neg_q | output | 1 | Result sign |
| zero_q | output | 1 | Result is zero |
| stat_q | output | 8 | Packed status byte |

## Verification
The bench builds the unit with its defaults: an 8-bit data path with the half-carry split after bit 3. At this width, all the signed and unsigned boundaries can be hit directly. These include 7Fh/80h sign flips, FFh+01h wraparound, 0Fh/10h nibble edges and borrow out of zero. Several thousand random vectors then cover all four operation codes and all hold-bit combinations. Because the data path is narrow, the flags of every vector can be checked in full against the arithmetic model.

// File: rtl/alu_flag_pkg.sv
`timescale 1ns/1ps
package alu_flag_pkg;

  // Operation codes: bit 1 selects subtract, bit 0 enables the carry/borrow input.
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_ADDC = 2'b01,
    OP_SUB  = 2'b10,
    OP_SUBB = 2'b11
  } alu_op_e;

  // Status byte bit positions (consumed by neighbouring logic, so fixed).
  localparam int STAT_W      = 8;
  localparam int STAT_CY     = 7;
  localparam int STAT_AC     = 6;
  localparam int STAT_USER   = 5;
  localparam int STAT_BANK_H = 4;
  localparam int STAT_BANK_L = 3;
  localparam int STAT_OV     = 2;
  localparam int STAT_ZERO   = 1;
  localparam int STAT_PAR    = 0;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
    logic par;
    logic neg;
    logic zero;
  } alu_flags_t;

endpackage

// File: rtl/alu_seg_add.sv
`timescale 1ns/1ps
module alu_seg_add #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] x,
  input  logic [SW-1:0] y,
  input  logic          ci,
  output logic [SW-1:0] s,
  output logic          co
);
  logic [SW:0] wide;
  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{SW{1'b0}}, ci};
    s    = wide[SW-1:0];
    co   = wide[SW];
  end
endmodule

// File: rtl/alu_addsub_core.sv
`timescale 1ns/1ps
module alu_addsub_core
  import alu_flag_pkg::*;
#(
  parameter int W   = 8,
  parameter int AUX = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  alu_op_e      op,
  output logic [W-1:0] sum,
  output logic         cy,
  output logic         ac,
  output logic         ov
);
  localparam int HI_W = W - AUX;

  logic         is_sub;
  logic         c_used;
  logic         c_lo_in;
  logic [W-1:0] b_eff;
  logic         co_lo;
  logic         co_hi;

  always_comb begin
    is_sub  = op[1];
    c_used  = op[0] & cin;
    b_eff   = is_sub ? ~b : b;
    // Subtract: A + ~B + 1 - borrow_in, so the injected carry is the inverted borrow.
    c_lo_in = is_sub ? ~c_used : c_used;
  end

  generate
    if (AUX > 0 && AUX < W) begin : g_split
      alu_seg_add #(.SW(AUX)) u_lo (
        .x (a[AUX-1:0]),
        .y (b_eff[AUX-1:0]),
        .ci(c_lo_in),
        .s (sum[AUX-1:0]),
        .co(co_lo)
      );
      alu_seg_add #(.SW(HI_W)) u_hi (
        .x (a[W-1:AUX]),
        .y (b_eff[W-1:AUX]),
        .ci(co_lo),
        .s (sum[W-1:AUX]),
        .co(co_hi)
      );
    end else begin : g_whole
      alu_seg_add #(.SW(W)) u_all (
        .x (a),
        .y (b_eff),
        .ci(c_lo_in),
        .s (sum),
        .co(co_hi)
      );
      assign co_lo = 1'b0;
    end
  endgenerate

  always_comb begin
    cy = is_sub ? ~co_hi : co_hi;
    ac = is_sub ? ~co_lo : co_lo;
    if (is_sub)
      ov = (a[W-1] != b[W-1]) && (sum[W-1] != a[W-1]);
    else
      ov = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_flag_pack.sv
`timescale 1ns/1ps
module alu_flag_pack
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]      sum,
  input  logic              cy,
  input  logic              ac,
  input  logic              ov,
  input  logic [2:0]        hold,
  output alu_flags_t        flags,
  output logic [STAT_W-1:0] stat
);
  always_comb begin
    flags.cy   = cy;
    flags.ac   = ac;
    flags.ov   = ov;
    flags.par  = ^sum;
    flags.neg  = sum[W-1];
    flags.zero = (sum == '0);

    stat              = '0;
    stat[STAT_CY]     = flags.cy;
    stat[STAT_AC]     = flags.ac;
    stat[STAT_USER]   = hold[2];
    stat[STAT_BANK_H] = hold[1];
    stat[STAT_BANK_L] = hold[0];
    stat[STAT_OV]     = flags.ov;
    stat[STAT_ZERO]   = flags.zero;
    stat[STAT_PAR]    = flags.par;
  end
endmodule

// File: rtl/alu_flag_unit.sv
`timescale 1ns/1ps
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W   = 8,
  parameter int AUX = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  logic         carry_in,
  input  logic [1:0]   op_sel,
  input  logic [2:0]   hold_bits,
  output logic [W-1:0] res_q,
  output logic         cy_q,
  output logic         ac_q,
  output logic         ov_q,
  output logic         par_q,
  output logic         neg_q,
  output logic         zero_q,
  output logic [7:0]   stat_q
);
  logic [W-1:0]      sum_c;
  logic              cy_c;
  logic              ac_c;
  logic              ov_c;
  alu_flags_t        flags_c;
  logic [STAT_W-1:0] stat_c;

  alu_addsub_core #(.W(W), .AUX(AUX)) u_core (
    .a  (opd_a),
    .b  (opd_b),
    .cin(carry_in),
    .op (alu_op_e'(op_sel)),
    .sum(sum_c),
    .cy (cy_c),
    .ac (ac_c),
    .ov (ov_c)
  );

  alu_flag_pack #(.W(W)) u_pack (
    .sum  (sum_c),
    .cy   (cy_c),
    .ac   (ac_c),
    .ov   (ov_c),
    .hold (hold_bits),
    .flags(flags_c),
    .stat (stat_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      cy_q   <= 1'b0;
      ac_q   <= 1'b0;
      ov_q   <= 1'b0;
      par_q  <= 1'b0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
      stat_q <= '0;
    end else begin
      res_q  <= sum_c;
      cy_q   <= flags_c.cy;
      ac_q   <= flags_c.ac;
      ov_q   <= flags_c.ov;
      par_q  <= flags_c.par;
      neg_q  <= flags_c.neg;
      zero_q <= flags_c.zero;
      stat_q <= stat_c;
    end
  end
endmodule

// File: rtl/alu_flag_unit_chk.sv
`timescale 1ns/1ps
module alu_flag_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opd_a,
  input logic [W-1:0] opd_b,
  input logic         carry_in,
  input logic [1:0]   op_sel,
  input logic [2:0]   hold_bits,
  input logic [W-1:0] res_q,
  input logic         cy_q,
  input logic         ov_q,
  input logic         par_q,
  input logic         zero_q,
  input logic [7:0]   stat_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_q == '0 && stat_q == 8'h00 && !cy_q && !ov_q));

  // R3
  add_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_sel[1])) |->
      (cy_q == (({1'b0, $past(opd_a)} + {1'b0, $past(opd_b)}
                 + {{W{1'b0}}, $past(op_sel[0]) & $past(carry_in)}) >> W)));

  // R6
  mixed_sign_add_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_sel[1]) && ($past(opd_a[W-1]) != $past(opd_b[W-1])))
      |-> !ov_q);

  // R7
  same_sign_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel[1]) && ($past(opd_a[W-1]) == $past(opd_b[W-1])))
      |-> !ov_q);

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    zero_q |-> (res_q == '0));

  // R10
  stat_layout_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stat_q[5:3] == $past(hold_bits) && stat_q[7] == cy_q
                     && stat_q[2] == ov_q && stat_q[0] == par_q));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opd_a    (opd_a),
  .opd_b    (opd_b),
  .carry_in (carry_in),
  .op_sel   (op_sel),
  .hold_bits(hold_bits),
  .res_q    (res_q),
  .cy_q     (cy_q),
  .ov_q     (ov_q),
  .par_q    (par_q),
  .zero_q   (zero_q),
  .stat_q   (stat_q)
);

// File: tb/alu_flag_unit_tb_top.sv
`timescale 1ns/1ps
module alu_flag_unit_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opd_a = '0;
  logic [W-1:0] opd_b = '0;
  logic         carry_in = 1'b0;
  logic [1:0]   op_sel = 2'b00;
  logic [2:0]   hold_bits = 3'b000;
  logic [W-1:0] res_q;
  logic         cy_q, ac_q, ov_q, par_q, neg_q, zero_q;
  logic [7:0]   stat_q;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  alu_flag_unit #(.W(W), .AUX(4)) dut_i (
    .clk(clk), .rst(rst), .opd_a(opd_a), .opd_b(opd_b), .carry_in(carry_in),
    .op_sel(op_sel), .hold_bits(hold_bits), .res_q(res_q), .cy_q(cy_q),
    .ac_q(ac_q), .ov_q(ov_q), .par_q(par_q), .neg_q(neg_q), .zero_q(zero_q),
    .stat_q(stat_q)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h (a=%h b=%h c=%0d op=%0d)",
               tag, what, act, exp, opd_a, opd_b, carry_in, op_sel);
    end
  endtask

  // Arithmetic model using plain integers; compare one clock after driving.
  task automatic apply_and_check(input int a, input int b, input int c, input int op,
                                 input int hold);
    int ci, r, full, lo, sa, sb, sr, e_cy, e_ac, e_ov, e_par, e_z, e_n, e_st;
    opd_a = a[7:0]; opd_b = b[7:0]; carry_in = c[0]; op_sel = op[1:0];
    hold_bits = hold[2:0];
    ci = (op % 2 == 1) ? c : 0;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    if (op < 2) begin
      full = a + b + ci;
      lo   = (a % 16) + (b % 16) + ci;
      sr   = sa + sb + ci;
      e_cy = (full > 255) ? 1 : 0;
      e_ac = (lo > 15) ? 1 : 0;
    end else begin
      full = a - b - ci;
      lo   = (a % 16) - (b % 16) - ci;
      sr   = sa - sb - ci;
      e_cy = (full < 0) ? 1 : 0;
      e_ac = (lo < 0) ? 1 : 0;
    end
    r = (full + 512) % 256;
    e_ov = (sr > 127 || sr < -128) ? 1 : 0;
    e_par = 0;
    for (int i = 0; i < 8; i++) e_par ^= (r >> i) & 1;
    e_z = (r == 0) ? 1 : 0;
    e_n = r / 128;
    e_st = e_cy * 128 + e_ac * 64 + hold * 8 + e_ov * 4 + e_z * 2 + e_par;
    @(negedge clk);
    chk("R2", "result", res_q, r[7:0]);
    chk(op < 2 ? "R3" : "R4", "cy", {7'd0, cy_q}, e_cy[7:0]);
    chk("R5", "ac", {7'd0, ac_q}, e_ac[7:0]);
    chk(op < 2 ? "R6" : "R7", "ov", {7'd0, ov_q}, e_ov[7:0]);
    chk("R8", "par", {7'd0, par_q}, e_par[7:0]);
    chk("R9", "zero", {7'd0, zero_q}, e_z[7:0]);
    chk("R9", "neg", {7'd0, neg_q}, e_n[7:0]);
    chk("R10", "stat", stat_q, e_st[7:0]);
  endtask

  task automatic check_cleared();
    chk("R1", "res", res_q, 8'h00);
    chk("R1", "stat", stat_q, 8'h00);
    chk("R1", "flags", {2'b00, cy_q, ac_q, ov_q, par_q, neg_q, zero_q}, 8'h00);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_cleared();                          // R1 at start
    rst = 1'b0;
    apply_and_check(8'h01, 8'hFF, 0, 0, 0);   // R3 wrap, CY=1, zero
    apply_and_check(8'h7F, 8'h01, 0, 0, 1);   // R6 positive overflow, AC
    apply_and_check(8'h80, 8'h80, 0, 0, 2);   // R6 negative overflow
    apply_and_check(8'h7F, 8'h80, 1, 1, 3);   // R6 mixed signs with carry
    apply_and_check(8'h0F, 8'h01, 0, 0, 4);   // R5 nibble carry
    apply_and_check(8'hFF, 8'h00, 1, 1, 5);   // R2 add-with-carry wraps
    apply_and_check(8'hFF, 8'h00, 1, 0, 6);   // R2 carry_in ignored on plain add
    apply_and_check(8'h00, 8'h01, 0, 2, 7);   // R4 borrow out of zero
    apply_and_check(8'h10, 8'h01, 0, 2, 0);   // R5 nibble borrow
    apply_and_check(8'h80, 8'h01, 0, 2, 1);   // R7 overflow
    apply_and_check(8'h7F, 8'hFF, 0, 2, 2);   // R7 overflow other direction
    apply_and_check(8'h80, 8'h00, 1, 3, 3);   // R7 borrow-in causes overflow
    apply_and_check(8'h05, 8'h05, 1, 2, 4);   // R2 borrow ignored on plain sub
    apply_and_check(8'h05, 8'h05, 1, 3, 5);   // R4 borrow-in gives FF
    apply_and_check(8'h03, 8'h00, 0, 0, 6);   // R8 even count
    apply_and_check(8'h07, 8'h00, 0, 0, 7);   // R8 odd count
    // R1 mid-run reset with live inputs
    opd_a = 8'hFF; opd_b = 8'hFF; op_sel = 2'b01; carry_in = 1'b1; hold_bits = 3'b111;
    rst = 1'b1;
    @(negedge clk);
    check_cleared();
    rst = 1'b0;
    for (int n = 0; n < 3000; n++)
      apply_and_check($urandom_range(0, 255), $urandom_range(0, 255),
                      $urandom_range(0, 1), $urandom_range(0, 3),
                      $urandom_range(0, 7));
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule